// File: doc/BRIEF.md
# Execute-Stage Logic and Arithmetic Unit

This block is the execute stage of a small stored-program processor. Each cycle it accepts an operation code and two 8-bit operands, computes a bitwise function, a ripple-carry sum or a shift, and presents the 8-bit result together with a carry flag on the following clock edge. The arithmetic path has no subtract operation. Software forms a negative operand by inverting it and adding one.

The shift operation takes its distance from the second operand, read as a signed two's-complement count. A positive count moves bits toward the least significant end and a negative count moves them toward the most significant end. Vacated positions are filled with zeros. A count whose magnitude reaches the data width empties the word. This lets a program isolate the sign of a difference by shifting it right by width minus one and branching on the result.

Top module: `alu_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` and `carry_o` both become 0 at that edge. Otherwise the result for the inputs sampled at an edge appears at the outputs right after that same edge, one registered stage with no other delay.
- R2: Operation codes: 1 = AND, 2 = OR, 3 = XOR, 4 = NOT, 5 = ADD, 6 = SHIFT. For codes 1, 2 and 3 the result is the bitwise function of `a_i` and `b_i`. Example: 0xB6 with 0x68 gives 0x20 (AND), 0xFE (OR) and 0xDE (XOR).
- R3: NOT (code 4) returns every bit of `a_i` inverted, and `b_i` has no effect on it. Example: 0x68 gives 0x97.
- R4: ADD (code 5) returns (`a_i` + `b_i`) modulo 256, formed by a carry chain that starts at bit 0 with a carry-in of 0. Example: 0x07 + 0xFD gives 0x04.
- R5: `carry_o` is the carry out of bit 7 of the addition for ADD. It is 0 for every other code.
- R6: SHIFT (code 6) with `b_i` read as a signed value from 1 to 7 moves `a_i` toward bit 0 by that many places. Zeros fill the top, and bits that leave bit 0 are lost. A count of 0 returns `a_i` unchanged.
- R7: SHIFT with a signed count from -1 to -7 moves `a_i` toward bit 7 by the magnitude of the count. Zeros fill the bottom, and bits that leave bit 7 are lost.
- R8: SHIFT with a signed count of 8 or more, or of -8 or less (including -128), returns 0.
- R9: Codes 0 and 7 to 15 return a result of 0 and a carry of 0.
- R10: SHIFT by a count of +7 returns 0x01 when bit 7 of `a_i` is set and 0x00 when it is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand; the shifted or inverted value |
| b_i | input | 8 | Second operand; the signed shift count for SHIFT |
| res_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry out of the addition |

## Verification
The properties assume that `op_i`, `a_i` and `b_i` are stable and known around every rising edge, since each check compares the registered outputs against the inputs sampled one edge earlier. They also assume that the cycle after a reset edge reflects the reset and not the operands, so every check is gated on the previous cycle being out of reset. The stimulus changes the inputs only on falling edges and always drives defined values. It applies reset once mid-run with live operands on the inputs, so the reset takes precedence over an ADD that would otherwise produce a carry.

// File: rtl/alu_exec_pkg.sv
`timescale 1ns/1ps
package alu_exec_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_NONE  = 4'd0,
        OPC_AND   = 4'd1,
        OPC_OR    = 4'd2,
        OPC_XOR   = 4'd3,
        OPC_NOT   = 4'd4,
        OPC_ADD   = 4'd5,
        OPC_SHIFT = 4'd6
    } opcode_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_INV = 2'd3
    } bitfn_e;

    typedef struct packed {
        logic   use_bitwise;
        logic   use_adder;
        logic   use_shifter;
        bitfn_e fn;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [OP_W-1:0] code);
        op_ctrl_t c;
        c.use_bitwise = 1'b0;
        c.use_adder   = 1'b0;
        c.use_shifter = 1'b0;
        c.fn          = BW_AND;
        case (code)
            OPC_AND:   begin c.use_bitwise = 1'b1; c.fn = BW_AND; end
            OPC_OR:    begin c.use_bitwise = 1'b1; c.fn = BW_OR;  end
            OPC_XOR:   begin c.use_bitwise = 1'b1; c.fn = BW_XOR; end
            OPC_NOT:   begin c.use_bitwise = 1'b1; c.fn = BW_INV; end
            OPC_ADD:   c.use_adder   = 1'b1;
            OPC_SHIFT: c.use_shifter = 1'b1;
            default:   ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise
    import alu_exec_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  bitfn_e       fn,
    output logic [W-1:0] out
);

    always_comb begin
        case (fn)
            BW_AND:  out = lhs & rhs;
            BW_OR:   out = lhs | rhs;
            BW_XOR:  out = lhs ^ rhs;
            default: out = ~lhs;
        endcase
    end

endmodule

// File: rtl/alu_ripple_adder.sv
`timescale 1ns/1ps
module alu_ripple_adder #(
    parameter int unsigned W = alu_exec_pkg::DATA_W
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        logic half;
        assign half       = lhs[i] ^ rhs[i];
        assign sum[i]     = half ^ chain[i];
        assign chain[i+1] = (half & chain[i]) | (lhs[i] & rhs[i]);
    end

    assign cout = chain[W];

endmodule

// File: rtl/alu_signed_shifter.sv
`timescale 1ns/1ps
module alu_signed_shifter #(
    parameter int unsigned W = alu_exec_pkg::DATA_W
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] count,
    output logic [W-1:0] out
);

    localparam int unsigned STG = (W > 1) ? $clog2(W) : 1;
    localparam int unsigned MW  = W + 1;

    logic          toward_msb;
    logic [MW-1:0] cnt_ext;
    logic [MW-1:0] mag;
    logic          too_far;
    logic [W-1:0]  stage [0:STG];

    assign toward_msb = count[W-1];
    assign cnt_ext    = {count[W-1], count};
    assign mag        = toward_msb ? (~cnt_ext + MW'(1)) : cnt_ext;
    assign too_far    = (mag >= MW'(W));

    assign stage[0] = data;

    for (genvar k = 0; k < STG; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        always_comb begin
            if (!mag[k])
                stage[k+1] = stage[k];
            else if (toward_msb)
                stage[k+1] = stage[k] << STEP;
            else
                stage[k+1] = stage[k] >> STEP;
        end
    end

    assign out = too_far ? '0 : stage[STG];

endmodule

// File: rtl/alu_exec_unit.sv
`timescale 1ns/1ps
module alu_exec_unit
    import alu_exec_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o,
    output logic            carry_o
);

    op_ctrl_t     ctrl;
    logic [W-1:0] bw_out;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] sh_out;
    logic [W-1:0] nxt_res;
    logic         nxt_carry;

    assign ctrl = decode_op(op_i);

    alu_bitwise #(.W(W)) u_bitwise (
        .lhs (a_i),
        .rhs (b_i),
        .fn  (ctrl.fn),
        .out (bw_out)
    );

    alu_ripple_adder #(.W(W)) u_adder (
        .lhs  (a_i),
        .rhs  (b_i),
        .sum  (add_sum),
        .cout (add_cout)
    );

    alu_signed_shifter #(.W(W)) u_shifter (
        .data  (a_i),
        .count (b_i),
        .out   (sh_out)
    );

    always_comb begin
        nxt_res   = '0;
        nxt_carry = 1'b0;
        if (ctrl.use_bitwise) begin
            nxt_res = bw_out;
        end else if (ctrl.use_adder) begin
            nxt_res   = add_sum;
            nxt_carry = add_cout;
        end else if (ctrl.use_shifter) begin
            nxt_res = sh_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o   <= '0;
            carry_o <= 1'b0;
        end else begin
            res_o   <= nxt_res;
            carry_o <= nxt_carry;
        end
    end

    // R1: the edge after a reset edge shows cleared outputs
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (res_o == '0 && carry_o == 1'b0));

    // R4, R5: registered sum and carry equal the full-width addition
    p_add_total_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == OPC_ADD)
        |-> ({carry_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

    // R5: carry stays low outside ADD
    p_carry_add_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) != OPC_ADD) |-> !carry_o);

    // R3: inversion ignores the second operand
    p_invert_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == OPC_NOT) |-> (res_o == ~$past(a_i)));

    // R8: out-of-range shift counts empty the word
    p_shift_range_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == OPC_SHIFT
         && ($signed($past(b_i)) >= $signed(W) || $signed($past(b_i)) <= -$signed(W)))
        |-> (res_o == '0));

    // R9: unassigned codes give zero
    p_unknown_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_i) == OPC_NONE || $past(op_i) > OPC_SHIFT))
        |-> (res_o == '0 && !carry_o));

endmodule

// File: tb/alu_exec_unit_bench.sv
`timescale 1ns/1ps
module alu_exec_unit_bench;

    localparam int unsigned W = 8;
    localparam int unsigned MAX_CYCLES = 199000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op  = 4'd0;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [W-1:0] res;
    logic         carry;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic         c;
        string        tag;
        int           issued;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    alu_exec_unit #(.W(W)) u_alu_exec_unit (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .res_o   (res),
        .carry_o (carry)
    );

    function automatic logic [W:0] model(input logic [3:0] o, input logic [W-1:0] x,
                                         input logic [W-1:0] y);
        int s;
        int sum;
        case (o)
            4'd1: return {1'b0, x & y};
            4'd2: return {1'b0, x | y};
            4'd3: return {1'b0, x ^ y};
            4'd4: return {1'b0, ~x};
            4'd5: begin
                sum = int'(x) + int'(y);
                return (W+1)'(sum);
            end
            4'd6: begin
                s = int'($signed(y));
                if (s >= int'(W) || s <= -int'(W)) return '0;
                if (s >= 0) return {1'b0, x >> s};
                return {1'b0, x << (-s)};
            end
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic [W-1:0] y);
        int s;
        s = int'($signed(y));
        case (o)
            4'd1, 4'd2, 4'd3: return "R2";
            4'd4: return "R3";
            4'd5: return "R4";
            4'd6: begin
                if (s == 7) return "R10";
                if (s >= int'(W) || s <= -int'(W)) return "R8";
                if (s >= 0) return "R6";
                return "R7";
            end
            default: return "R9";
        endcase
    endfunction

    task automatic drive(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        exp_t e;
        logic [W:0] m;
        @(negedge clk);
        rst = 1'b0;
        op  = o;
        a   = x;
        b   = y;
        m   = model(o, x, y);
        e.res    = m[W-1:0];
        e.c      = m[W];
        e.tag    = tag_of(o, y);
        e.issued = cyc;
        sb.push_back(e);
    endtask

    task automatic drive_reset(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        exp_t e;
        @(negedge clk);
        rst = 1'b1;
        op  = o;
        a   = x;
        b   = y;
        e.res    = '0;
        e.c      = 1'b0;
        e.tag    = "R1";
        e.issued = cyc;
        sb.push_back(e);
    endtask

    // Monitor: pops the item issued before the latest rising edge
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0 && sb[0].issued < cyc) begin
            e = sb.pop_front();
            checks++;
            if (res !== e.res) begin
                errors++;
                $display("FAIL %s result: actual %h expected %h", e.tag, res, e.res);
            end
            checks++;
            if (carry !== e.c) begin
                errors++;
                $display("FAIL R5 carry (%s): actual %b expected %b", e.tag, carry, e.c);
            end
        end
    end

    initial begin
        #(8 * MAX_CYCLES);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs cleared while reset is held
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (res !== '0 || carry !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: actual %h/%b expected 00/0", res, carry);
        end

        // Directed cases from the requirements
        drive(4'd1, 8'hB6, 8'h68);
        drive(4'd2, 8'hB6, 8'h68);
        drive(4'd3, 8'hB6, 8'h68);
        drive(4'd4, 8'h68, 8'h00);
        drive(4'd4, 8'h68, 8'hFF);   // R3 second operand ignored
        drive(4'd5, 8'h07, 8'hFD);   // R4 truncated sum, R5 carry set
        drive(4'd5, 8'hFF, 8'h01);
        drive(4'd6, 8'h96, 8'h07);   // R10 sign bit set
        drive(4'd6, 8'h6A, 8'h07);   // R10 sign bit clear
        drive(4'd6, 8'hB4, 8'hFE);   // R7 left by two
        drive(4'd6, 8'hB4, 8'h00);   // R6 zero count
        drive(4'd6, 8'hFF, 8'h80);   // R8 count -128
        drive(4'd6, 8'hFF, 8'h08);
        drive(4'd6, 8'hFF, 8'hF8);
        drive(4'd0, 8'hFF, 8'hFF);   // R9
        drive(4'd7, 8'hFF, 8'hFF);
        drive(4'd15, 8'h80, 8'h80);

        // R1: reset wins over a live ADD with carry
        drive_reset(4'd5, 8'hFF, 8'hFF);
        drive(4'd5, 8'h80, 8'h80);

        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                drive(4'd5, W'(x), W'(y));
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                drive(4'd6, W'(x), W'(y));
        for (int o = 1; o <= 3; o++)
            for (int x = 0; x < 256; x++)
                for (int y = 0; y < 256; y += 7)
                    drive(4'(o), W'(x), W'(y));
        for (int x = 0; x < 256; x++)
            drive(4'd4, W'(x), W'(x * 3));
        for (int o = 7; o < 16; o++)
            drive(4'(o), W'(o * 17), W'(o * 5));

        repeat (3) @(negedge clk);
        #2;
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard drain: actual %0d left expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule